// File: doc/BRIEF.md
# Control Endpoint Receive Handler

This block handles the receive direction of the default control endpoint in a low-speed USB function. A serial interface engine delivers already decoded events to it: a token strobe with its type, a start strobe for the DATA packet that follows, the packet bytes one per cycle (CRC bytes included), and an end strobe that carries the packet error flag and the data PID toggle. The block places received bytes into an eight-entry endpoint buffer. It keeps an 8-bit status register for firmware. It returns the handshake the engine must send, and it pulses an interrupt once a good packet has been recorded.

Three firmware controls set the response to OUT traffic: stall, OUT enable and status-stage OUT. These controls are latched at the start of each DATA packet. A SETUP token sets a sticky flag. While that flag is set, firmware writes into the buffer are dropped, so request data cannot be corrupted. The flag cannot be cleared until the DATA packet that follows the SETUP has ended.

Top module: `ctl_ep_rx`

## Requirements
- R1: After reset the status register, the invalid flag, the interrupt and the handshake strobe are all 0, and every buffer entry reads 0.
- R2: Token encoding on tok_type_i is 0 = OUT, 1 = IN, 2 = SETUP. On each token, status bit 1 becomes 1 for OUT and 0 otherwise, and status bit 2 becomes 1 for IN and 0 otherwise.
- R3: A SETUP token sets status bit 0. The bit stays set until a firmware status write. A status write that comes between a SETUP token and the end of the DATA packet after it leaves bit 0 set.
- R4: A firmware status write sets status bits 7:4, 2, 1 and 0 to 0 (bit 0 subject to R3) and leaves bit 3 unchanged.
- R5: While status bit 0 is 1, a firmware buffer write has no effect. When bit 0 is 0, the write stores its byte.
- R6: The count in status bits 7:4 equals the number of received bytes including the two CRC bytes. Byte k of the packet is stored at buffer entry k, for k below 8, so CRC bytes follow short payloads.
- R7: DATA after SETUP always updates the count, updates the toggle in status bit 3, and stores its bytes.
- R8: DATA after OUT updates the count and toggle only when stall is 0 and at least one of OUT enable or status OUT is 1. It stores bytes only when OUT enable is 1 and both stall and status OUT are 0.
- R9: A packet is in error when pkt_err_i is set at its end or when it has more than 8 payload bytes. An error sets rx_invalid_o. The flag clears at the start of a packet that is accepted for update.
- R10: irq_o is a single-cycle pulse, raised only for a packet that updated the count and is not in error. It appears in the same cycle as the updated status.
- R11: Handshake codes are 0 = none, 1 = ACK, 2 = NAK, 3 = STALL. The rules are checked in this order: an error gets none; a SETUP gets ACK; an OUT gets STALL if stall is set; an OUT gets NAK if neither OUT enable nor status OUT is set; an OUT gets STALL if status OUT is set and the payload is not empty; anything else gets ACK. hs_valid_o pulses for one cycle with the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tok_valid_i | input | 1 | Token strobe for this endpoint |
| tok_type_i | input | 2 | Token kind (0 OUT, 1 IN, 2 SETUP) |
| pkt_start_i | input | 1 | DATA packet begins |
| byte_valid_i | input | 1 | rx_byte_i holds a packet byte |
| rx_byte_i | input | 8 | Received byte, CRC bytes included |
| pkt_end_i | input | 1 | DATA packet ends |
| pkt_err_i | input | 1 | CRC, PID or bit-stuffing error, valid with pkt_end_i |
| pkt_toggle_i | input | 1 | DATA PID toggle, valid with pkt_end_i |
| stall_i | input | 1 | Stall control |
| en_outs_i | input | 1 | OUT enable control |
| stat_outs_i | input | 1 | Status-stage OUT control |
| stat_we_i | input | 1 | Firmware status register write |
| buf_we_i | input | 1 | Firmware buffer write |
| buf_waddr_i | input | 3 | Firmware buffer write entry |
| buf_wdata_i | input | 8 | Firmware buffer write byte |
| buf_raddr_i | input | 3 | Buffer read entry |
| buf_rdata_o | output | 8 | Buffer read byte (combinational) |
| stat_o | output | 8 | Status register |
| rx_invalid_o | output | 1 | Receive data invalid flag |
| irq_o | output | 1 | Endpoint interrupt pulse |
| hs_valid_o | output | 1 | Handshake strobe |
| hs_o | output | 2 | Handshake code |

## Verification
A fault in the latched packet policy shows one cycle after the end strobe. At that point the status count, the toggle bit, the interrupt pulse and the handshake code all disagree with the controls that were in force when the packet started. A broken store enable or a broken byte index is only seen when the buffer is read back, so the bench reads all eight entries after every packet. A SETUP flag that stays set or clears too early shows up at the next firmware status write or buffer write. These are probed both inside and outside the window that runs from the SETUP token to the end of its DATA packet.

// File: rtl/ctl_ep_rx_pkg.sv
package ctl_ep_rx_pkg;
  typedef enum logic [1:0] {
    TOK_OUT   = 2'd0,
    TOK_IN    = 2'd1,
    TOK_SETUP = 2'd2
  } tok_e;

  typedef enum logic [1:0] {
    HS_NONE  = 2'd0,
    HS_ACK   = 2'd1,
    HS_NAK   = 2'd2,
    HS_STALL = 2'd3
  } hs_e;

  typedef struct packed {
    logic stall;
    logic en_outs;
    logic stat_outs;
  } ctrl_t;
endpackage

// File: rtl/ctl_ep_rx_policy.sv
module ctl_ep_rx_policy
  import ctl_ep_rx_pkg::*;
(
  input  logic  setup_i,
  input  logic  out_i,
  input  ctrl_t ctrl_i,
  input  logic  err_i,
  input  logic  zero_len_i,
  output logic  upd_o,
  output logic  store_o,
  output hs_e   hs_o
);
  logic any_out;
  assign any_out = ctrl_i.en_outs | ctrl_i.stat_outs;

  assign upd_o   = setup_i | (out_i & ~ctrl_i.stall & any_out);
  assign store_o = setup_i | (out_i & ctrl_i.en_outs & ~ctrl_i.stall & ~ctrl_i.stat_outs);

  always_comb begin
    hs_o = HS_ACK;
    if (!(setup_i || out_i))                  hs_o = HS_NONE;
    else if (err_i)                           hs_o = HS_NONE;
    else if (setup_i)                         hs_o = HS_ACK;
    else if (ctrl_i.stall)                    hs_o = HS_STALL;
    else if (!any_out)                        hs_o = HS_NAK;
    else if (ctrl_i.stat_outs && !zero_len_i) hs_o = HS_STALL; // bad status stage
    else                                      hs_o = HS_ACK;
  end
endmodule

// File: rtl/ctl_ep_rx_bytes.sv
module ctl_ep_rx_bytes #(
  parameter int DEPTH = 8,
  parameter int CNT_W = 4,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic             byte_valid_i,
  input  logic             store_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wr_en_o,
  output logic [AW-1:0]    wr_addr_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;
  localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                  cnt_q <= '0;
    else if (start_i)                             cnt_q <= '0;
    else if (byte_valid_i && (cnt_q != CNT_MAX))  cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o     = cnt_q;
  assign wr_en_o   = byte_valid_i & store_i & (cnt_q < DEPTH_C);
  assign wr_addr_o = cnt_q[AW-1:0];
endmodule

// File: rtl/ctl_ep_rx_buf.sv
module ctl_ep_rx_buf #(
  parameter int DEPTH = 8,
  parameter int DW    = 8,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          a_we_i,
  input  logic [AW-1:0] a_addr_i,
  input  logic [DW-1:0] a_data_i,
  input  logic          b_we_i,
  input  logic [AW-1:0] b_addr_i,
  input  logic [DW-1:0] b_data_i,
  input  logic [AW-1:0] raddr_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] mem_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                               mem_q[g] <= '0;
      else if (a_we_i && a_addr_i == AW'(g))     mem_q[g] <= a_data_i; // engine has priority
      else if (b_we_i && b_addr_i == AW'(g))     mem_q[g] <= b_data_i;
    end
  end

  assign rdata_o = mem_q[raddr_i];
endmodule

// File: rtl/ctl_ep_rx_stat.sv
module ctl_ep_rx_stat
  import ctl_ep_rx_pkg::*;
#(
  parameter int CNT_W = 4,
  localparam int SW = CNT_W + 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tok_valid_i,
  input  tok_e             tok_type_i,
  input  logic             cpu_we_i,
  input  logic             hold_setup_i,
  input  logic             rx_upd_i,
  input  logic             toggle_i,
  input  logic [CNT_W-1:0] cnt_i,
  output logic [SW-1:0]    stat_o
);
  logic [SW-1:0] q, nxt;

  always_comb begin
    nxt = q;
    if (cpu_we_i) begin
      nxt    = '0;
      nxt[3] = q[3];
      nxt[0] = q[0] & hold_setup_i;
    end
    if (tok_valid_i) begin
      if (tok_type_i == TOK_SETUP) nxt[0] = 1'b1;
      nxt[1] = (tok_type_i == TOK_OUT);
      nxt[2] = (tok_type_i == TOK_IN);
    end
    if (rx_upd_i) begin
      nxt[3]    = toggle_i;
      nxt[SW-1:4] = cnt_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q <= '0;
    else         q <= nxt;
  end

  assign stat_o = q;
endmodule

// File: rtl/ctl_ep_rx.sv
module ctl_ep_rx
  import ctl_ep_rx_pkg::*;
#(
  parameter int DEPTH     = 8,
  parameter int DW        = 8,
  parameter int CRC_BYTES = 2,
  parameter int CNT_W     = 4,
  localparam int AW = $clog2(DEPTH),
  localparam int SW = CNT_W + 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tok_valid_i,
  input  logic [1:0]    tok_type_i,
  input  logic          pkt_start_i,
  input  logic          byte_valid_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          pkt_end_i,
  input  logic          pkt_err_i,
  input  logic          pkt_toggle_i,
  input  logic          stall_i,
  input  logic          en_outs_i,
  input  logic          stat_outs_i,
  input  logic          stat_we_i,
  input  logic          buf_we_i,
  input  logic [AW-1:0] buf_waddr_i,
  input  logic [DW-1:0] buf_wdata_i,
  input  logic [AW-1:0] buf_raddr_i,
  output logic [DW-1:0] buf_rdata_o,
  output logic [SW-1:0] stat_o,
  output logic          rx_invalid_o,
  output logic          irq_o,
  output logic          hs_valid_o,
  output logic [1:0]    hs_o
);
  localparam logic [CNT_W-1:0] MAX_CNT = CNT_W'(DEPTH + CRC_BYTES);
  localparam logic [CNT_W-1:0] CRC_C   = CNT_W'(CRC_BYTES);

  tok_e             tok_w;
  tok_e             last_tok_q;
  ctrl_t            ctrl_q;
  logic             kind_setup_q, kind_out_q, start_d_q, lock_q;
  logic             upd_w, store_w, err_w, zero_len_w;
  hs_e              hs_w, hs_q;
  logic [CNT_W-1:0] cnt_w;
  logic             sie_we, cpu_we;
  logic [AW-1:0]    sie_waddr;
  logic             inv_q, irq_q, hs_valid_q;

  assign tok_w = tok_e'(tok_type_i);

  // context of the packet, fixed at its start
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      last_tok_q   <= TOK_IN;
      kind_setup_q <= 1'b0;
      kind_out_q   <= 1'b0;
      ctrl_q       <= '0;
      start_d_q    <= 1'b0;
      lock_q       <= 1'b0;
    end else begin
      start_d_q <= pkt_start_i;
      if (tok_valid_i) last_tok_q <= tok_w;
      if (pkt_start_i) begin
        kind_setup_q <= (last_tok_q == TOK_SETUP);
        kind_out_q   <= (last_tok_q == TOK_OUT);
        ctrl_q       <= '{stall: stall_i, en_outs: en_outs_i, stat_outs: stat_outs_i};
      end
      if (tok_valid_i)    lock_q <= (tok_w == TOK_SETUP);
      else if (pkt_end_i) lock_q <= 1'b0;
    end
  end

  assign err_w      = pkt_err_i | (cnt_w > MAX_CNT);
  assign zero_len_w = (cnt_w == CRC_C);

  ctl_ep_rx_policy u_pol (
    .setup_i   (kind_setup_q),
    .out_i     (kind_out_q),
    .ctrl_i    (ctrl_q),
    .err_i     (err_w),
    .zero_len_i(zero_len_w),
    .upd_o     (upd_w),
    .store_o   (store_w),
    .hs_o      (hs_w)
  );

  ctl_ep_rx_bytes #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_byt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .start_i     (pkt_start_i),
    .byte_valid_i(byte_valid_i),
    .store_i     (store_w),
    .cnt_o       (cnt_w),
    .wr_en_o     (sie_we),
    .wr_addr_o   (sie_waddr)
  );

  assign cpu_we = buf_we_i & ~stat_o[0];

  ctl_ep_rx_buf #(.DEPTH(DEPTH), .DW(DW)) u_buf (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .a_we_i  (sie_we),
    .a_addr_i(sie_waddr),
    .a_data_i(rx_byte_i),
    .b_we_i  (cpu_we),
    .b_addr_i(buf_waddr_i),
    .b_data_i(buf_wdata_i),
    .raddr_i (buf_raddr_i),
    .rdata_o (buf_rdata_o)
  );

  ctl_ep_rx_stat #(.CNT_W(CNT_W)) u_st (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .tok_valid_i (tok_valid_i),
    .tok_type_i  (tok_w),
    .cpu_we_i    (stat_we_i),
    .hold_setup_i(lock_q),
    .rx_upd_i    (pkt_end_i & upd_w),
    .toggle_i    (pkt_toggle_i),
    .cnt_i       (cnt_w),
    .stat_o      (stat_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      inv_q      <= 1'b0;
      irq_q      <= 1'b0;
      hs_valid_q <= 1'b0;
      hs_q       <= HS_NONE;
    end else begin
      if (pkt_end_i && (kind_setup_q || kind_out_q) && err_w) inv_q <= 1'b1;
      else if (start_d_q && upd_w)                            inv_q <= 1'b0;
      irq_q      <= pkt_end_i & upd_w & ~err_w;
      hs_valid_q <= pkt_end_i & (kind_setup_q | kind_out_q);
      if (pkt_end_i) hs_q <= hs_w;
    end
  end

  assign rx_invalid_o = inv_q;
  assign irq_o        = irq_q;
  assign hs_valid_o   = hs_valid_q;
  assign hs_o         = hs_q;
endmodule

// File: rtl/ctl_ep_rx_chk.sv
module ctl_ep_rx_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       tok_valid_i,
  input logic [1:0] tok_type_i,
  input logic       stat_we_i,
  input logic       pkt_end_i,
  input logic [7:0] stat_o,
  input logic       rx_invalid_o,
  input logic       irq_o,
  input logic       hs_valid_o
);
  p_setup_flag_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && tok_type_i == 2'd2 |=> stat_o[0]);

  p_sticky_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_o[0] && !stat_we_i |=> stat_o[0]);

  p_out_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && tok_type_i == 2'd0 |=> stat_o[1] && !stat_o[2]);

  p_in_flags_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tok_valid_i && tok_type_i == 2'd1 |=> stat_o[2] && !stat_o[1]);

  p_wr_clear_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stat_we_i && !tok_valid_i && !pkt_end_i
    |=> stat_o[7:4] == 4'd0 && stat_o[2:1] == 2'd0 && stat_o[3] == $past(stat_o[3]));

  p_irq_pulse_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |=> !irq_o);

  p_irq_clean_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> !rx_invalid_o && hs_valid_o);
endmodule

bind ctl_ep_rx ctl_ep_rx_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .tok_valid_i (tok_valid_i),
  .tok_type_i  (tok_type_i),
  .stat_we_i   (stat_we_i),
  .pkt_end_i   (pkt_end_i),
  .stat_o      (stat_o),
  .rx_invalid_o(rx_invalid_o),
  .irq_o       (irq_o),
  .hs_valid_o  (hs_valid_o)
);

// File: tb/sim_ctl_ep_rx.sv
`timescale 1ns/1ps
module sim_ctl_ep_rx;
  logic       clk = 1'b0, rst_ni = 1'b0;
  logic       tok_valid = 0, pkt_start = 0, byte_valid = 0, pkt_end = 0, pkt_err = 0, pkt_tog = 0;
  logic [1:0] tok_type = 0;
  logic [7:0] rx_byte = 0, buf_wdata = 0, buf_rdata, stat;
  logic       stall = 0, en_outs = 0, stat_outs = 0, stat_we = 0, buf_we = 0;
  logic [2:0] buf_waddr = 0, buf_raddr = 0;
  logic       inv, irq, hs_valid;
  logic [1:0] hs;

  int n_chk = 0, n_err = 0;
  logic [7:0] m_stat = 0, m_buf [8];
  logic       m_inv = 0, m_lock = 0;
  int         m_last = 1;

  always #10 clk = ~clk;

  ctl_ep_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .tok_valid_i(tok_valid), .tok_type_i(tok_type),
    .pkt_start_i(pkt_start), .byte_valid_i(byte_valid), .rx_byte_i(rx_byte),
    .pkt_end_i(pkt_end), .pkt_err_i(pkt_err), .pkt_toggle_i(pkt_tog),
    .stall_i(stall), .en_outs_i(en_outs), .stat_outs_i(stat_outs),
    .stat_we_i(stat_we), .buf_we_i(buf_we), .buf_waddr_i(buf_waddr), .buf_wdata_i(buf_wdata),
    .buf_raddr_i(buf_raddr), .buf_rdata_o(buf_rdata), .stat_o(stat),
    .rx_invalid_o(inv), .irq_o(irq), .hs_valid_o(hs_valid), .hs_o(hs)
  );

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_hs(int setup, int n, bit e);
    if (e) return 0;
    if (setup) return 1;
    if (stall) return 3;
    if (!en_outs && !stat_outs) return 2;
    if (stat_outs && n != 0) return 3;
    return 1;
  endfunction

  task automatic check_buf(input string req);
    for (int i = 0; i < 8; i++) begin
      buf_raddr = 3'(i);
      #1;
      chk(req, int'(buf_rdata), int'(m_buf[i]));
    end
  endtask

  task automatic send_token(input int t);
    @(negedge clk); tok_valid = 1; tok_type = 2'(t);
    @(negedge clk); tok_valid = 0;
    if (t == 2) m_stat[0] = 1'b1;
    m_stat[1] = (t == 0);
    m_stat[2] = (t == 1);
    m_lock = (t == 2);
    m_last = t;
    chk("R2/R3 token flags", int'(stat), int'(m_stat));
  endtask

  task automatic stat_write();
    @(negedge clk); stat_we = 1;
    @(negedge clk); stat_we = 0;
    m_stat = {4'd0, m_stat[3], 2'd0, m_stat[0] & m_lock};
    chk("R4/R3 status write", int'(stat), int'(m_stat));
  endtask

  task automatic cpu_buf_write(input int a, input int d);
    @(negedge clk); buf_we = 1; buf_waddr = 3'(a); buf_wdata = 8'(d);
    @(negedge clk); buf_we = 0;
    if (!m_stat[0]) m_buf[a] = 8'(d);
    buf_raddr = 3'(a);
    #1;
    chk("R5 cpu buffer write", int'(buf_rdata), int'(m_buf[a]));
  endtask

  task automatic send_data(input int n, input bit e, input bit tog);
    logic [7:0] d [16];
    int  cnt = n + 2;
    bit  setup = (m_last == 2);
    bit  upd = setup || (!stall && (en_outs || stat_outs));
    bit  store = setup || (en_outs && !stall && !stat_outs);
    bit  err = e || (n > 8);
    int  h = exp_hs(int'(setup), n, err);
    for (int i = 0; i < 16; i++) d[i] = 8'($urandom);
    @(negedge clk); pkt_start = 1;
    @(negedge clk); pkt_start = 0;
    for (int i = 0; i < cnt; i++) begin
      byte_valid = 1; rx_byte = d[i];
      @(negedge clk);
    end
    byte_valid = 0;
    pkt_end = 1; pkt_err = e; pkt_tog = tog;
    @(negedge clk); pkt_end = 0; pkt_err = 0;
    if (store) for (int i = 0; i < cnt && i < 8; i++) m_buf[i] = d[i];
    if (upd) begin m_inv = 0; m_stat[3] = tog; m_stat[7:4] = 4'(cnt); end
    if (err) m_inv = 1;
    m_lock = 0;
    chk("R6/R7/R8 status after packet", int'(stat), int'(m_stat));
    chk("R9 invalid flag", int'(inv), int'(m_inv));
    chk("R10 irq pulse", int'(irq), int'(upd && !err));
    chk("R11 hs strobe", int'(hs_valid), 1);
    chk("R11 hs code", int'(hs), h);
    @(negedge clk);
    chk("R10 irq single cycle", int'(irq), 0);
    chk("R11 hs strobe single cycle", int'(hs_valid), 0);
    check_buf("R6/R8 buffer contents");
  endtask

  task automatic set_ctrl(input bit s, input bit en, input bit so);
    @(negedge clk); stall = s; en_outs = en; stat_outs = so;
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog act=running exp=done");
    finish_run();
  end

  initial begin
    void'($urandom(32'h5eed1234));
    for (int i = 0; i < 8; i++) m_buf[i] = 8'd0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 status", int'(stat), 0);
    chk("R1 invalid", int'(inv), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 hs strobe", int'(hs_valid), 0);
    rst_ni = 1;
    check_buf("R1 buffer");

    // R3/R5: SETUP lock, status write before its data keeps bit 0
    send_token(2);
    stat_write();
    chk("R3 bit0 held during setup data", int'(stat[0]), 1);
    cpu_buf_write(2, 8'hA5);
    send_data(8, 0, 1);
    cpu_buf_write(0, 8'h3C);
    stat_write();
    chk("R3 bit0 cleared after data", int'(stat[0]), 0);
    chk("R4 toggle kept", int'(stat[3]), 1);
    cpu_buf_write(0, 8'h3C);

    // R11 status stage handling
    set_ctrl(0, 0, 1); send_token(0); send_data(0, 0, 0);
    set_ctrl(0, 0, 1); send_token(0); send_data(3, 0, 1);
    set_ctrl(1, 1, 0); send_token(0); send_data(2, 0, 0);
    set_ctrl(0, 0, 0); send_token(0); send_data(4, 0, 1);
    set_ctrl(0, 1, 0); send_token(0); send_data(5, 0, 1);
    // R9 errors: flagged error and oversize payload
    set_ctrl(0, 1, 0); send_token(0); send_data(4, 1, 0);
    set_ctrl(0, 1, 0); send_token(0); send_data(9, 0, 1);
    set_ctrl(0, 1, 0); send_token(0); send_data(1, 0, 0);
    send_token(1);

    for (int it = 0; it < 250; it++) begin
      int r = int'($urandom % 10);
      set_ctrl(1'($urandom % 4 == 0), 1'($urandom), 1'($urandom % 3 == 0));
      if ($urandom % 3 == 0) stat_write();
      if ($urandom % 4 == 0) cpu_buf_write(int'($urandom % 8), int'($urandom % 256));
      if (r < 3) begin
        send_token(2);
        if ($urandom % 3 == 0) stat_write();
        if ($urandom % 3 == 0) cpu_buf_write(int'($urandom % 8), int'($urandom % 256));
        send_data(int'($urandom % 12), 1'($urandom % 6 == 0), 1'($urandom));
      end else if (r < 9) begin
        send_token(0);
        send_data(int'($urandom % 12), 1'($urandom % 6 == 0), 1'($urandom));
      end else begin
        send_token(1);
      end
    end
    finish_run();
  end
endmodule